// File: doc/BRIEF.md
# Pipeline Activity Tracker

This block decides whether a multi-stage pipeline still holds work in flight, so that the pipeline can be put to sleep or its clock stopped once nothing remains to do. Two sources of work feed it. The first is traffic between stages: any stage that writes data into an inter-stage buffer pulses a report. The block records that report as a 1 in the newest slot of an aging register, which has one slot per cycle of the longest inter-stage latency. The second source is the set of stages that declare themselves busy. Each such stage has its own flag, set and cleared through separate requests.

A single occupancy counter follows the number of occupied slots plus the number of busy stages. The pipeline may idle only while that counter is zero. The counter can also be forced to any value. Loading a nonzero value keeps the pipeline awake, which turns idling off. The gating logic and the data buffers themselves sit outside this block.

Top module: `actv_tracker`

## Requirements
- R1: After reset, and after any later reset, the count is 0, `active` is low, every slot is empty and every stage flag is clear.
- R2: A write report without an advance sets slot 0. If slot 0 was empty, the count rises by 1. If slot 0 was already set, the count does not change.
- R3: Each advance moves every slot one place toward the oldest end. A 1 that is shifted out of the oldest slot lowers the count by 1. A report sampled without an advance leaves the block on the LATENCY-th advance after it. A report sampled together with an advance leaves on the LATENCY-th advance after that cycle.
- R4: When a write report and an advance arrive in the same cycle, the shift is done first. The new 1 then lands in the emptied slot 0 and always adds 1 to the count, while the bit leaving the oldest slot subtracts as in R3.
- R5: Raising `stageOn[i]` for an inactive stage i sets its flag and adds 1 to the count. Raising `stageOff[i]` for an active stage i clears its flag and subtracts 1.
- R6: The following requests change neither the flag nor the count: activating a stage that is already active, deactivating a stage that is already inactive, and asserting `stageOn[i]` and `stageOff[i]` in the same cycle.
- R7: `active` is high exactly when the count is nonzero.
- R8: `loadEn` puts `loadVal` into the count in the next cycle and overrides every increment and decrement of that cycle. The slots and the stage flags still update as usual in that cycle.
- R9: The count saturates. It never drops below 0 and never goes past 2^CNT_W-1, where CNT_W = clog2(LATENCY+NUM_STAGES+1).
- R10: As long as no load has occurred since reset, the count equals the number of set slots plus the number of active stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrPulse | input | 1 | A stage wrote inter-stage data this cycle |
| advance | input | 1 | Shift the aging register by one place |
| stageOn | input | NUM_STAGES | Per-stage activate request, bit i is stage i |
| stageOff | input | NUM_STAGES | Per-stage deactivate request, bit i is stage i |
| loadEn | input | 1 | Load `loadVal` into the counter |
| loadVal | input | CNT_W | Value to load |
| count | output | CNT_W | Occupancy counter |
| active | output | 1 | Count is nonzero |

## Verification
A faulty slot or stage flag cannot be seen at once. It shows up only when that state would change the count: a slot reaches the oldest end after LATENCY advances, or a stage is deactivated, or a redundant request is made. For this reason the stimulus drives every tracked bit all the way out of the block and then checks that the count returns to exactly zero. A counter that drifts from its sources is caught in the same cycle by the invariant check. At the ports it appears as `active` that stays high, or that falls while a stage is still busy.

// File: rtl/actv_pkg.sv
package actv_pkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic shift;       // age every slot by one place
    logic markNewest;  // write a 1 into slot 0 after any shift
    logic slotInc;     // slot 0 goes from empty to occupied
    logic load;        // counter takes the load value
  } actvStrobe_t;
endpackage

// File: rtl/actv_ctrl.sv
module actv_ctrl
  import actv_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  localparam int STG_W = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrPulse,
  input  logic                  advance,
  input  logic                  loadEn,
  input  logic [NUM_STAGES-1:0] stageOn,
  input  logic [NUM_STAGES-1:0] stageOff,
  input  logic                  newestBit,
  output actvStrobe_t           strobe,
  output logic [STG_W-1:0]      stageUp,
  output logic [STG_W-1:0]      stageDown,
  output logic [STG_W-1:0]      stageCount
);

  logic [NUM_STAGES-1:0] flagQ;
  logic [NUM_STAGES-1:0] goOn;
  logic [NUM_STAGES-1:0] goOff;

  generate
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      assign goOn[i]  = stageOn[i] & ~stageOff[i] & ~flagQ[i];
      assign goOff[i] = stageOff[i] & ~stageOn[i] & flagQ[i];
      always_ff @(posedge clk) begin
        if (!rstN)          flagQ[i] <= 1'b0;
        else if (goOn[i])   flagQ[i] <= 1'b1;
        else if (goOff[i])  flagQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    stageUp    = '0;
    stageDown  = '0;
    stageCount = '0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      stageUp    = stageUp + STG_W'(goOn[i]);
      stageDown  = stageDown + STG_W'(goOff[i]);
      stageCount = stageCount + STG_W'(flagQ[i]);
    end
  end

  // shift first, so a write in an advancing cycle always finds slot 0 empty
  always_comb begin
    strobe.shift      = advance;
    strobe.markNewest = wrPulse;
    strobe.slotInc    = wrPulse & (advance | ~newestBit);
    strobe.load       = loadEn;
  end

  // R6: a conflicting request leaves the flag untouched
  a_r6_conflict_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ ^ $past(flagQ)) & $past(stageOn & stageOff)) == '0);

  // R5: a lone activate request always leaves the flag set
  a_r5_activate_sets: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (flagQ & $past(stageOn & ~stageOff)) == $past(stageOn & ~stageOff));

  // R5: a lone deactivate request always leaves the flag clear
  a_r5_deactivate_clears: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (flagQ & $past(stageOff & ~stageOn)) == '0);

endmodule

// File: rtl/actv_datapath.sv
module actv_datapath
  import actv_pkg::*;
#(
  parameter int LATENCY    = 5,
  parameter int NUM_STAGES = 4,
  localparam int CNT_W = $clog2(LATENCY + NUM_STAGES + 1),
  localparam int STG_W = $clog2(NUM_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  actvStrobe_t       strobe,
  input  logic [STG_W-1:0]  stageUp,
  input  logic [STG_W-1:0]  stageDown,
  input  logic [STG_W-1:0]  stageCount,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  count,
  output logic              newestBit
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [LATENCY-1:0] slotsQ;
  logic [LATENCY-1:0] slotsD;
  logic [CNT_W-1:0]   countQ;
  logic [CNT_W-1:0]   countD;
  logic               slotDec;
  int                 sumTmp;

  assign slotDec   = strobe.shift & slotsQ[LATENCY-1];
  assign newestBit = slotsQ[0];

  generate
    if (LATENCY == 1) begin : g_single
      always_comb begin
        slotsD = strobe.shift ? 1'b0 : slotsQ;
        if (strobe.markNewest) slotsD[0] = 1'b1;
      end
    end else begin : g_chain
      always_comb begin
        slotsD = strobe.shift ? {slotsQ[LATENCY-2:0], 1'b0} : slotsQ;
        if (strobe.markNewest) slotsD[0] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    sumTmp = int'(countQ) + int'(strobe.slotInc) + int'(stageUp)
           - int'(slotDec) - int'(stageDown);
    if (strobe.load)            countD = loadVal;
    else if (sumTmp < 0)        countD = '0;
    else if (sumTmp > CNT_MAX)  countD = CNT_W'(CNT_MAX);
    else                        countD = sumTmp[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotsQ <= '0;
      countQ <= '0;
    end else begin
      slotsQ <= slotsD;
      countQ <= countD;
    end
  end

  assign count = countQ;

  // checking aid: the tally invariant only holds until the first load
  logic everLoaded;
  always_ff @(posedge clk) begin
    if (!rstN)            everLoaded <= 1'b0;
    else if (strobe.load) everLoaded <= 1'b1;
  end

  // R10: counter matches occupied slots plus busy stages
  a_r10_tally: assert property (@(posedge clk) disable iff (!rstN)
    !everLoaded |-> int'(countQ) == $countones(slotsQ) + int'(stageCount));

  // R2: a repeated write with nothing else going on leaves the count alone
  a_r2_repeat_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.markNewest && !strobe.shift && slotsQ[0] && !strobe.load &&
     stageUp == '0 && stageDown == '0) |=> $stable(countQ));

  // R4: a write during an advance always ends up in slot 0
  a_r4_write_after_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && strobe.markNewest) |=> slotsQ[0]);

  // R8: a load wins over everything else
  a_r8_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> countQ == $past(loadVal));

  // R9: a count of zero with no additions stays at zero
  a_r9_floor: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0 && !strobe.load && !strobe.markNewest && stageUp == '0)
      |=> countQ == '0);

endmodule

// File: rtl/actv_tracker.sv
module actv_tracker
  import actv_pkg::*;
#(
  parameter int LATENCY    = 5,
  parameter int NUM_STAGES = 4,
  localparam int CNT_W = $clog2(LATENCY + NUM_STAGES + 1),
  localparam int STG_W = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrPulse,
  input  logic                  advance,
  input  logic [NUM_STAGES-1:0] stageOn,
  input  logic [NUM_STAGES-1:0] stageOff,
  input  logic                  loadEn,
  input  logic [CNT_W-1:0]      loadVal,
  output logic [CNT_W-1:0]      count,
  output logic                  active
);

  actvStrobe_t      strobe;
  logic [STG_W-1:0] stageUp;
  logic [STG_W-1:0] stageDown;
  logic [STG_W-1:0] stageCount;
  logic             newestBit;

  actv_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrPulse    (wrPulse),
    .advance    (advance),
    .loadEn     (loadEn),
    .stageOn    (stageOn),
    .stageOff   (stageOff),
    .newestBit  (newestBit),
    .strobe     (strobe),
    .stageUp    (stageUp),
    .stageDown  (stageDown),
    .stageCount (stageCount)
  );

  actv_datapath #(.LATENCY(LATENCY), .NUM_STAGES(NUM_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stageUp    (stageUp),
    .stageDown  (stageDown),
    .stageCount (stageCount),
    .loadVal    (loadVal),
    .count      (count),
    .newestBit  (newestBit)
  );

  assign active = |count;

  // R7: active follows the count on every cycle
  a_r7_active: assert property (@(posedge clk) disable iff (!rstN)
    active == (count != '0));

endmodule

// File: tb/actv_tracker_bench.sv
module actv_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrPulse = 1'b0;
  logic          advance = 1'b0;
  logic [NS-1:0] stageOn = '0;
  logic [NS-1:0] stageOff = '0;
  logic          loadEn = 1'b0;
  logic [CW-1:0] loadVal = '0;
  logic [CW-1:0] count;
  logic          active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  actv_tracker u_actv_tracker (
    .clk(clk), .rstN(rstN), .wrPulse(wrPulse), .advance(advance),
    .stageOn(stageOn), .stageOff(stageOff), .loadEn(loadEn),
    .loadVal(loadVal), .count(count), .active(active)
  );

  // {wr, adv, on[3:0], off[3:0], expected count}, LATENCY = 5
  localparam logic [13:0] VECS [19] = '{
    {1'b1, 1'b0, 4'h0, 4'h0, 4'd1},  // R2 first write
    {1'b1, 1'b0, 4'h0, 4'h0, 4'd1},  // R2 repeated write
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd1},  // R3 shift to slot 1
    {1'b1, 1'b0, 4'h0, 4'h0, 4'd2},  // R2 fresh slot 0
    {1'b0, 1'b0, 4'h3, 4'h0, 4'd4},  // R5 two stages on
    {1'b0, 1'b0, 4'h1, 4'h0, 4'd4},  // R6 redundant on
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd4},  // R3
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd4},  // R3
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd4},  // R3 slots 3,4
    {1'b1, 1'b1, 4'h0, 4'h0, 4'd4},  // R4 drop and write together
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd3},  // R3 second drop
    {1'b0, 1'b0, 4'h0, 4'h1, 4'd2},  // R5 stage 0 off
    {1'b0, 1'b0, 4'h0, 4'h1, 4'd2},  // R6 redundant off
    {1'b0, 1'b0, 4'h4, 4'h4, 4'd2},  // R6 conflicting request
    {1'b0, 1'b0, 4'h0, 4'h2, 4'd1},  // R5 stage 1 off
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd1},  // R3
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd1},  // R3
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd1},  // R3
    {1'b0, 1'b1, 4'h0, 4'h0, 4'd0}   // R3 last slot leaves, R7 idle
  };

  task automatic check(input string req, input logic [CW-1:0] expCount);
    checks++;
    if (count !== expCount || active !== (expCount != 0)) begin
      fails++;
      $display("FAIL %s: count=%0d active=%0b expected count=%0d active=%0b",
               req, count, active, expCount, expCount != 0);
    end
  endtask

  task automatic step(input logic wr, input logic adv, input logic [NS-1:0] on,
                      input logic [NS-1:0] off, input logic ld, input logic [CW-1:0] lv);
    wrPulse = wr; advance = adv; stageOn = on; stageOff = off;
    loadEn = ld; loadVal = lv;
    @(negedge clk);
    wrPulse = 1'b0; advance = 1'b0; stageOn = '0; stageOff = '0; loadEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset state", 4'd0);
    @(negedge clk);
    check("R1 idle after reset", 4'd0);

    for (int i = 0; i < 19; i++) begin
      step(VECS[i][13], VECS[i][12], VECS[i][11:8], VECS[i][7:4], 1'b0, '0);
      check($sformatf("R2-R7 vector %0d", i), VECS[i][3:0]);
    end

    // R8 load overrides the write increment of the same cycle
    step(1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 4'd15);
    check("R8 load max", 4'd15);
    // R9 upper clamp
    step(1'b0, 1'b0, 4'h1, 4'h0, 1'b0, '0);
    check("R9 clamp high", 4'd15);
    // R8 load zero while a slot and a stage are occupied
    step(1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 4'd0);
    check("R8 load zero", 4'd0);
    // R9 lower clamp
    step(1'b0, 1'b0, 4'h0, 4'h1, 1'b0, '0);
    check("R9 clamp low", 4'd0);
    // R8 flags still updated during a load: stage 2 on under load, then off
    step(1'b0, 1'b0, 4'h4, 4'h0, 1'b1, 4'd6);
    check("R8 load with activate", 4'd6);
    step(1'b0, 1'b0, 4'h0, 4'h4, 1'b0, '0);
    check("R8 flag set under load", 4'd5);

    // R1 mid-run reset clears slots and flags
    step(1'b1, 1'b0, 4'h2, 4'h0, 1'b0, '0);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 count cleared by reset", 4'd0);
    rstN = 1'b1;
    step(1'b0, 1'b0, 4'h2, 4'h0, 1'b0, '0);
    check("R1 stage flag cleared", 4'd1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 4'h0, 4'h0, 1'b0, '0);
    check("R1 slots cleared", 4'd1);

    // R3 timing: a write with advance leaves on the fifth later advance
    step(1'b1, 1'b1, 4'h0, 4'h0, 1'b0, '0);
    check("R4 write with advance", 4'd2);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 4'h0, 4'h0, 1'b0, '0);
    check("R3 still held after 4 advances", 4'd2);
    step(1'b0, 1'b1, 4'h0, 4'h0, 1'b0, '0);
    check("R3 dropped on 5th advance", 4'd1);
    step(1'b0, 1'b0, 4'h0, 4'h2, 1'b0, '0);
    check("R7 idle at end", 4'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule